// File: doc/BRIEF.md
# Four-Channel DAC Serial Load Front End

This block is the digital front end of a four-channel, 16-bit DAC. A host shifts 32-bit words in over a three-wire serial link: an active-low frame select, a serial clock and a data line sampled on the falling edges of the serial clock. Each completed word carries a command, a channel address and a 16-bit value. Every channel holds two levels of storage: a staging register that receives written data and an output register whose value drives the converter.

Staging data reaches the output registers in one of two ways. If the update strobe is held low, a write also updates the output register it addresses. If the strobe is high, writes stay staged until a falling edge on the strobe moves all four staged values to the outputs at once. A falling edge on the clear strobe forces every register to a programmable clear level. A strap input selects the start-up level. All four serial and strobe pins are sampled into the system clock domain, so the system clock must run at least four times faster than the serial clock.

Top module: `qdac_load_if`

## Requirements
- R1: A word is accepted only on the 32nd serial clock falling edge after frame select goes low. Bits arrive MSB first: bits 27:24 are the command, bits 23:20 the address and bits 19:4 the data, and bits 31:28 and 3:0 are ignored. Further falling edges before frame select rises are ignored. Command 0 with the update strobe high writes only the staging register, so the output is unchanged.
- R2: If frame select rises before the 32nd falling edge, the partial word is dropped and no register changes.
- R3: If the update strobe is low when a command 0 word completes, the addressed output register also takes the data.
- R4: A falling edge of the update strobe, with the clear strobe high, copies all four staging registers into their output registers in the same cycle.
- R5: Command 1 copies the addressed staging register to its output. Command 3 writes the data to both registers of the addressed channel. Command 2 writes the addressed staging register and then copies all four staging registers to the outputs.
- R6: Address values 0 to 3 select channels A to D and address 15 selects all four. Addresses 4 to 14 have no effect with any command.
- R7: Command 5 loads the clear code from data bits 1:0: 00 gives zero scale, 01 midscale and 10 full scale. Code 11 leaves the clear code unchanged. The clear code resets to zero scale.
- R8: A falling edge of the clear strobe loads every staging and output register with the clear level: 0x0000, 0x8000 or 0xFFFF.
- R9: While the clear strobe is low, falling edges of the update strobe are ignored. Frames still write the staging registers.
- R10: After reset, every staging and output register holds 0x0000 if the start-up strap is low, or 0x8000 if it is high.
- R11: When a word completes in the same cycle as an update strobe falling edge, the outputs take the staging values including that word's write. When a word completes in the same cycle as a clear falling edge, the clear wins and the word is dropped.
- R12: Commands 4 and 6 to 15 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 4x the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_mid_i | input | 1 | Start-up strap: 0 for zero scale, 1 for midscale |
| ser_clk_i | input | 1 | Serial clock; data is sampled on its falling edges |
| frame_ni | input | 1 | Active-low frame select |
| ser_dat_i | input | 1 | Serial data, MSB first |
| upd_ni | input | 1 | Update strobe: a low level means immediate update, a falling edge means update all |
| clear_ni | input | 1 | Clear strobe, acts on its falling edge |
| dac_o | output | 64 | Output register values, channel A in bits 15:0 up to channel D in bits 63:48 |

## Verification
Two collisions can occur in a single cycle. The completion of a word can meet an update strobe falling edge, and it can also meet a clear strobe falling edge. The bench causes each one by dropping the strobe at the same system clock edge as the 32nd serial clock fall, so all three pass through synchronizers of equal depth together. For the update collision, the bench expects the outputs to include the staging write just made. For the clear collision, it expects the clear level and afterwards shows, through an update strobe pulse, that the dropped word never reached the staging register.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int HEAD_W = 4;
  localparam int CMD_W  = 4;
  localparam int ADDR_W = 4;
  localparam int TAIL_W = 4;

  localparam logic [CMD_W-1:0] CMD_WR      = 4'd0;
  localparam logic [CMD_W-1:0] CMD_UPD     = 4'd1;
  localparam logic [CMD_W-1:0] CMD_WR_ALL  = 4'd2;
  localparam logic [CMD_W-1:0] CMD_WR_UPD  = 4'd3;
  localparam logic [CMD_W-1:0] CMD_CCODE   = 4'd5;

  typedef enum logic [1:0] {
    CC_ZERO = 2'd0,
    CC_MID  = 2'd1,
    CC_FULL = 2'd2,
    CC_RSVD = 2'd3
  } ccode_e;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/qdac_frame_rx.sv
module qdac_frame_rx #(
  parameter int FW     = 32,
  parameter int HEAD_W = 4,
  parameter int BODY_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              fall_i,
  input  logic              dat_i,
  output logic              vld_o,
  output logic [BODY_W-1:0] body_o
);
  localparam int CNT_W = $clog2(FW + 1);
  localparam logic [CNT_W-1:0] BODY_LO = CNT_W'(HEAD_W);
  localparam logic [CNT_W-1:0] BODY_HI = CNT_W'(HEAD_W + BODY_W);
  localparam logic [CNT_W-1:0] LAST    = CNT_W'(FW - 1);
  localparam logic [CNT_W-1:0] FULL    = CNT_W'(FW);

  logic [CNT_W-1:0]  cnt_q;
  logic [BODY_W-1:0] sh_q;
  logic              in_body;

  assign in_body = (cnt_q >= BODY_LO) && (cnt_q < BODY_HI);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (!active_i) begin
      cnt_q <= '0;
    end else if (fall_i && (cnt_q < FULL)) begin
      cnt_q <= cnt_q + 1'b1;
      if (in_body) sh_q <= {sh_q[BODY_W-2:0], dat_i};
    end
  end

  // head and tail bits are only counted; body is frozen after its last bit
  assign vld_o  = active_i && fall_i && (cnt_q == LAST);
  assign body_o = sh_q;
endmodule

// File: rtl/qdac_ccode.sv
module qdac_ccode
  import qdac_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] val_i,
  output logic [1:0] code_o
);
  ccode_e code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= CC_ZERO;
    end else if (wr_i && (ccode_e'(val_i) != CC_RSVD)) begin
      code_q <= ccode_e'(val_i);
    end
  end

  assign code_o = code_q;
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
  import qdac_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NCH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_mid_i,
  input  logic              vld_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic              upd_low_i,
  input  logic              upd_fall_i,
  input  logic              clr_fall_i,
  input  logic [1:0]        code_i,
  output logic [NCH*DW-1:0] dac_o
);
  localparam logic [DW-1:0]     MID_VAL  = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0]     FULL_VAL = {DW{1'b1}};
  localparam logic [ADDR_W-1:0] ADDR_ALL = {ADDR_W{1'b1}};

  logic           init_q;
  logic [NCH-1:0] sel;
  logic           any_sel;
  logic [DW-1:0]  clr_val;
  logic [DW-1:0]  start_val;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) init_q <= 1'b1;
    else         init_q <= 1'b0;
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      sel[c] = (addr_i == ADDR_W'(c)) || (addr_i == ADDR_ALL);
    end
  end
  assign any_sel = |sel;

  always_comb begin
    unique case (ccode_e'(code_i))
      CC_MID:  clr_val = MID_VAL;
      CC_FULL: clr_val = FULL_VAL;
      default: clr_val = '0;
    endcase
  end

  assign start_val = start_mid_i ? MID_VAL : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [DW-1:0] in_q, in_nxt;
    logic [DW-1:0] out_q, out_nxt;

    always_comb begin
      in_nxt  = in_q;
      out_nxt = out_q;
      if (init_q) begin
        in_nxt  = start_val;
        out_nxt = start_val;
      end else if (clr_fall_i) begin
        in_nxt  = clr_val;
        out_nxt = clr_val;
      end else begin
        if (vld_i && sel[c]) begin
          unique case (cmd_i)
            CMD_WR: begin
              in_nxt = data_i;
              if (upd_low_i) out_nxt = data_i;
            end
            CMD_UPD:    out_nxt = in_q;
            CMD_WR_ALL: in_nxt  = data_i;
            CMD_WR_UPD: begin
              in_nxt  = data_i;
              out_nxt = data_i;
            end
            default: ;
          endcase
        end
        // broadcast update sees this word's write
        if (vld_i && (cmd_i == CMD_WR_ALL) && any_sel) out_nxt = in_nxt;
        if (upd_fall_i) out_nxt = in_nxt;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        in_q  <= '0;
        out_q <= '0;
      end else begin
        in_q  <= in_nxt;
        out_q <= out_nxt;
      end
    end

    assign dac_o[c*DW +: DW] = out_q;
  end
endmodule

// File: rtl/qdac_load_if.sv
module qdac_load_if
  import qdac_pkg::*;
#(
  parameter int DW  = 16,
  parameter int NCH = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_mid_i,
  input  logic              ser_clk_i,
  input  logic              frame_ni,
  input  logic              ser_dat_i,
  input  logic              upd_ni,
  input  logic              clear_ni,
  output logic [NCH*DW-1:0] dac_o
);
  localparam int BODY_W = CMD_W + ADDR_W + DW;
  localparam int FW     = HEAD_W + BODY_W + TAIL_W;
  localparam int NSYNC  = 5;
  // order: clear, update, frame, serial clock, serial data
  localparam logic [NSYNC-1:0] SYNC_RST = 5'b11100;

  logic [NSYNC-1:0] raw, syn;
  logic clear_s, upd_s, frame_s, ser_clk_s, ser_dat_s;
  logic clear_p_q, upd_p_q, ser_clk_p_q;
  logic ser_fall, upd_fall_raw, upd_fall, clr_fall;
  logic              frame_vld;
  logic [BODY_W-1:0] body;
  logic [1:0]        clr_code;
  logic              code_wr;

  assign raw = {clear_ni, upd_ni, frame_ni, ser_clk_i, ser_dat_i};

  qdac_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw),
    .q_o   (syn)
  );

  assign {clear_s, upd_s, frame_s, ser_clk_s, ser_dat_s} = syn;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clear_p_q   <= 1'b1;
      upd_p_q     <= 1'b1;
      ser_clk_p_q <= 1'b0;
    end else begin
      clear_p_q   <= clear_s;
      upd_p_q     <= upd_s;
      ser_clk_p_q <= ser_clk_s;
    end
  end

  assign ser_fall     = ser_clk_p_q & ~ser_clk_s;
  assign upd_fall_raw = upd_p_q & ~upd_s;
  assign clr_fall     = clear_p_q & ~clear_s;
  assign upd_fall     = upd_fall_raw & clear_s;

  qdac_frame_rx #(.FW(FW), .HEAD_W(HEAD_W), .BODY_W(BODY_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .active_i(~frame_s),
    .fall_i  (ser_fall),
    .dat_i   (ser_dat_s),
    .vld_o   (frame_vld),
    .body_o  (body)
  );

  assign code_wr = frame_vld && !clr_fall &&
                   (body[BODY_W-1 -: CMD_W] == CMD_CCODE);

  qdac_ccode u_ccode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .wr_i  (code_wr),
    .val_i (body[1:0]),
    .code_o(clr_code)
  );

  qdac_regs #(.DW(DW), .NCH(NCH)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_mid_i(start_mid_i),
    .vld_i      (frame_vld),
    .cmd_i      (body[BODY_W-1 -: CMD_W]),
    .addr_i     (body[DW +: ADDR_W]),
    .data_i     (body[DW-1:0]),
    .upd_low_i  (~upd_s),
    .upd_fall_i (upd_fall),
    .clr_fall_i (clr_fall),
    .code_i     (clr_code),
    .dac_o      (dac_o)
  );
endmodule

// File: rtl/qdac_load_if_chk.sv
module qdac_load_if_chk #(
  parameter int DW  = 16,
  parameter int NCH = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_vld_i,
  input logic              upd_fall_i,
  input logic              clr_lvl_i,
  input logic              clr_fall_i,
  input logic [1:0]        code_i,
  input logic [NCH*DW-1:0] dac_i
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  function automatic logic [DW-1:0] lvl(input logic [1:0] c);
    if (c == 2'd1)      return {1'b1, {(DW-1){1'b0}}};
    else if (c == 2'd2) return {DW{1'b1}};
    else                return '0;
  endfunction

  p_vld_pulse_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_i |=> !frame_vld_i);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && !frame_vld_i && !upd_fall_i && !clr_fall_i) |=> $stable(dac_i));

  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && clr_fall_i) |=> (dac_i == {NCH{lvl($past(code_i))}}));

  p_upd_block_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && upd_fall_i && !clr_lvl_i && !frame_vld_i && !clr_fall_i)
      |=> $stable(dac_i));
endmodule

bind qdac_load_if qdac_load_if_chk #(.DW(DW), .NCH(NCH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_vld_i(frame_vld),
  .upd_fall_i (upd_fall_raw),
  .clr_lvl_i  (clear_s),
  .clr_fall_i (clr_fall),
  .code_i     (clr_code),
  .dac_i      (dac_o)
);

// File: tb/qdac_load_if_tb.sv
module qdac_load_if_tb;
  localparam int CLK_PERIOD = 10;
  localparam int H = 3;

  logic clk = 1'b0;
  logic rst_n, start_mid, ser_clk, frame_n, ser_dat, upd_n, clear_n;
  logic [63:0] dac_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  qdac_load_if u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_mid_i(start_mid),
    .ser_clk_i  (ser_clk),
    .frame_ni   (frame_n),
    .ser_dat_i  (ser_dat),
    .upd_ni     (upd_n),
    .clear_ni   (clear_n),
    .dac_o      (dac_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // behavioural reference, evaluated on the raw pins
  logic [15:0] st_in[4], st_out[4], n_in[4], n_out[4];
  logic [1:0]  m_code;
  logic [31:0] m_word;
  int          m_bits, since_rst;
  logic        pv_clk, pv_upd, pv_clr;
  logic [63:0] hist[$];

  function automatic logic [63:0] snap();
    return {st_out[3], st_out[2], st_out[1], st_out[0]};
  endfunction

  function automatic logic [15:0] level(input logic [1:0] c);
    case (c)
      2'd1: return 16'h8000;
      2'd2: return 16'hFFFF;
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        st_in[c]  = start_mid ? 16'h8000 : 16'h0000;
        st_out[c] = start_mid ? 16'h8000 : 16'h0000;
      end
      m_code = 2'd0; m_bits = 0; m_word = 0; since_rst = 0;
      hist.delete();
    end else begin
      bit got, cf, lf;
      logic [3:0] cmd, adr;
      logic [15:0] val;
      got = 0;
      if (frame_n) m_bits = 0;
      else if (pv_clk && !ser_clk && m_bits < 32) begin
        m_word = {m_word[30:0], ser_dat};
        m_bits++;
        if (m_bits == 32) got = 1;
      end
      cf = pv_clr && !clear_n;
      lf = pv_upd && !upd_n && clear_n;
      cmd = m_word[27:24]; adr = m_word[23:20]; val = m_word[19:4];
      for (int c = 0; c < 4; c++) begin n_in[c] = st_in[c]; n_out[c] = st_out[c]; end
      if (cf) begin
        for (int c = 0; c < 4; c++) begin n_in[c] = level(m_code); n_out[c] = level(m_code); end
      end else begin
        if (got) begin
          for (int c = 0; c < 4; c++) begin
            bit hit;
            hit = (adr == c) || (adr == 15);
            if (hit && cmd == 0) begin n_in[c] = val; if (!upd_n) n_out[c] = val; end
            if (hit && cmd == 1) n_out[c] = st_in[c];
            if (hit && cmd == 2) n_in[c] = val;
            if (hit && cmd == 3) begin n_in[c] = val; n_out[c] = val; end
          end
          if (cmd == 2 && (adr < 4 || adr == 15))
            for (int c = 0; c < 4; c++) n_out[c] = n_in[c];
          if (cmd == 5 && val[1:0] != 2'd3) m_code = val[1:0];
        end
        if (lf) for (int c = 0; c < 4; c++) n_out[c] = n_in[c];
      end
      for (int c = 0; c < 4; c++) begin st_in[c] = n_in[c]; st_out[c] = n_out[c]; end
      hist.push_back(snap());
      if (hist.size() > 3) void'(hist.pop_front());
      since_rst++;
    end
    pv_clk = ser_clk; pv_upd = upd_n; pv_clr = clear_n;
  end

  always @(negedge clk) begin
    if (rst_n && since_rst >= 4 && hist.size() == 3)
      check(cur_req, dac_o, hist[0]);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [3:0] cmd, input logic [3:0] adr, input logic [15:0] d,
                      input int nedge = 32, input bit upd_last = 0, input bit clr_last = 0);
    logic [31:0] w;
    w = {4'h0, cmd, adr, d, 4'h0};
    tick(1);
    frame_n = 1'b0;
    tick(H);
    for (int i = 0; i < nedge; i++) begin
      ser_clk = 1'b1; ser_dat = w[31-i];
      tick(H);
      ser_clk = 1'b0;
      if (i == nedge - 1) begin
        if (upd_last) upd_n = 1'b0;
        if (clr_last) clear_n = 1'b0;
      end
      tick(H);
    end
    tick(H);
    frame_n = 1'b1;
    tick(2*H);
  endtask

  task automatic pulse_upd();
    upd_n = 1'b0; tick(4); upd_n = 1'b1; tick(5);
  endtask

  task automatic pulse_clr();
    clear_n = 1'b0; tick(4); clear_n = 1'b1; tick(5);
  endtask

  initial begin
    ser_clk = 0; frame_n = 1; ser_dat = 0; upd_n = 1; clear_n = 1;
    start_mid = 0; rst_n = 0;
    tick(5); rst_n = 1; tick(5);
    cur_req = "R10"; check("R10 zero-scale start", dac_o, 64'h0);

    cur_req = "R1"; send(0, 0, 16'h1234); check("R1 staged write leaves output", dac_o, 64'h0);
    cur_req = "R4"; pulse_upd(); check("R4 strobe copies staging", dac_o, 64'h0000_0000_0000_1234);

    cur_req = "R3"; upd_n = 0; tick(5); send(0, 1, 16'hBEEF);
    check("R3 immediate update", dac_o, 64'h0000_0000_BEEF_1234);
    upd_n = 1; tick(5);

    cur_req = "R2"; send(0, 2, 16'h5555); send(0, 2, 16'h7777, 20); pulse_upd();
    check("R2 partial frame dropped", dac_o, 64'h0000_5555_BEEF_1234);

    cur_req = "R5"; send(3, 3, 16'hC0DE); check("R5 write+update", dac_o, 64'hC0DE_5555_BEEF_1234);
    send(0, 0, 16'h1111); send(1, 0, 16'h0); check("R5 copy addressed", dac_o, 64'hC0DE_5555_BEEF_1111);
    send(2, 1, 16'h2222); check("R5 write+update all", dac_o, 64'hC0DE_5555_2222_1111);

    cur_req = "R6"; send(0, 15, 16'h3333); pulse_upd();
    check("R6 broadcast address", dac_o, {4{16'h3333}});
    send(3, 7, 16'h4444); pulse_upd(); check("R6 unused address", dac_o, {4{16'h3333}});

    cur_req = "R12"; send(9, 0, 16'h6666); send(4, 15, 16'h6666); pulse_upd();
    check("R12 unknown commands", dac_o, {4{16'h3333}});

    cur_req = "R8"; send(5, 0, 16'h0002); pulse_clr(); check("R8 full-scale clear", dac_o, {4{16'hFFFF}});
    send(5, 0, 16'h0001); pulse_clr(); check("R8 midscale clear", dac_o, {4{16'h8000}});
    cur_req = "R7"; send(5, 0, 16'h0003); pulse_clr(); check("R7 code 11 ignored", dac_o, {4{16'h8000}});
    send(5, 0, 16'h0000); pulse_clr(); pulse_upd(); check("R7 zero clear, staging cleared", dac_o, 64'h0);

    cur_req = "R9"; clear_n = 0; tick(5); send(0, 15, 16'h9999); pulse_upd();
    check("R9 strobe blocked by clear", dac_o, 64'h0);
    clear_n = 1; tick(5); pulse_upd(); check("R9 staging kept", dac_o, {4{16'h9999}});

    cur_req = "R11"; send(0, 0, 16'h1357); send(0, 2, 16'hABCD, 32, 1, 0); upd_n = 1; tick(5);
    check("R11 word and strobe together", dac_o, 64'h9999_ABCD_9999_1357);
    send(0, 1, 16'hEEEE, 32, 0, 1); clear_n = 1; tick(5);
    check("R11 clear beats word", dac_o, 64'h0);
    pulse_upd(); check("R11 dropped word not staged", dac_o, 64'h0);

    cur_req = "R10"; start_mid = 1; rst_n = 0; tick(5); rst_n = 1; tick(5);
    check("R10 midscale start", dac_o, {4{16'h8000}});
    pulse_upd(); check("R10 staging at midscale", dac_o, {4{16'h8000}});
    cur_req = "R7"; pulse_clr(); check("R7 clear code resets to zero", dac_o, 64'h0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog %s act=hung exp=done", cur_req);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule